// File: doc/BRIEF.md
# Widening Pairwise Add/Subtract Unit

This block takes one 128-bit vector, splits it into equal elements, and combines each two neighbouring elements into one result of twice the element width. The element size can be bytes, 16-bit halfwords or 32-bit words. The results are 16-bit, 32-bit or 64-bit values, and they are packed from the least significant end of the output. The two elements of a pair can be added as signed values or as unsigned values. They can also be subtracted as signed values, in which case the odd element is taken from the even one. Each result is one bit-width step wider than its operands, so it always holds the exact value and no saturation logic is needed.

The unit sits inside a SIMD execute stage. The issuing logic presents a source vector, a size code and an operation code, together with a valid strobe. By default the result is registered: it appears one cycle later with its own valid flag and is held until the next accepted operation. Setting a parameter removes the output register and makes the datapath combinational.

Top module: `hadd_widen`

## Requirements
- R1: With size code 0, output halfword i (bits 16i+15..16i) is formed from source bytes 2i (even) and 2i+1 (odd), for i = 0..7.
- R2: With size code 1, output 32-bit lane i is formed from source halfwords 2i (even) and 2i+1 (odd), for i = 0..3.
- R3: With size code 2, output 64-bit lane i is formed from source words 2i (even) and 2i+1 (odd), for i = 0..1.
- R4: Op code 1 adds the two elements after zero-extending both; for example bytes 0xFF + 0xFF give 0x01FE.
- R5: Op code 0 adds the two elements after sign-extending both; for example bytes 0x80 + 0x80 give 0xFF00.
- R6: Op code 2 subtracts the odd element from the even element after sign-extending both; for example 0x7F - 0x80 gives 0x00FF, and 0x80 - 0x7F gives 0xFF01.
- R7: With the registered output, valid_o is high in exactly the cycles that follow a cycle in which valid_i was high.
- R8: With the registered output, data_o changes only on a clock edge where valid_i is high, and otherwise keeps its value.
- R9: Size code 3 or op code 3 produces an all-zero result.
- R10: While reset is active, and after it is released until the first operation is accepted, valid_o and data_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| src_i | input | 128 | Source vector |
| size_i | input | 2 | Element size: 0 byte, 1 halfword, 2 word, 3 reserved |
| op_i | input | 2 | Operation: 0 signed add, 1 unsigned add, 2 signed subtract, 3 reserved |
| valid_o | output | 1 | Result valid |
| data_o | output | 128 | Widened pairwise results |

## Verification
For bytes, the bench drives all 65536 even/odd value pairs through each of the three operations. This covers the extremes that a wrong choice between sign and zero extension turns into a wrong upper byte: 0x80 becomes 0x0080 instead of 0xFF80. It also covers a subtract with the operands swapped, which gives the negated result, and a result lane taken from the wrong pair, which shows up as a value from a different position. For halfwords and words, the bench combines corner values (zero, all ones, the most negative and the most positive value) with pseudo-random vectors. This catches a carry that is dropped at bit 32 of the 64-bit form. Reserved codes must give zero. With valid_i low, a changed source must leave data_o untouched, so an output register that loads on every cycle shows up at once.

// File: rtl/hadd_pkg.sv
package hadd_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    OP_SADD = 2'd0,
    OP_UADD = 2'd1,
    OP_SSUB = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/hadd_pair.sv
module hadd_pair #(
  parameter int unsigned SRC_W = 8,
  localparam int unsigned DST_W = 2 * SRC_W
) (
  input  logic [SRC_W-1:0] even_i,
  input  logic [SRC_W-1:0] odd_i,
  input  logic             sext_i,
  input  logic             sub_i,
  output logic [DST_W-1:0] res_o
);
  logic [DST_W-1:0] even_x, odd_x;

  always_comb begin
    even_x = {{SRC_W{sext_i & even_i[SRC_W-1]}}, even_i};
    odd_x  = {{SRC_W{sext_i & odd_i[SRC_W-1]}}, odd_i};
    res_o  = sub_i ? (even_x - odd_x) : (even_x + odd_x);
  end

  // widened result carries no more than one growth bit
  always_comb begin
    if (!$isunknown({even_i, odd_i, sext_i, sub_i})) begin
      if (!sext_i) begin
        p_uadd_headroom_r4: assert (res_o[DST_W-1:SRC_W+1] == '0);
      end else if (!sub_i) begin
        p_sadd_signfill_r5: assert (res_o[DST_W-1:SRC_W] == '0 || res_o[DST_W-1:SRC_W] == '1);
      end else begin
        p_ssub_signfill_r6: assert (res_o[DST_W-1:SRC_W] == '0 || res_o[DST_W-1:SRC_W] == '1);
      end
    end
  end
endmodule

// File: rtl/hadd_row.sv
module hadd_row #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned SRC_W = 8,
  localparam int unsigned DST_W = 2 * SRC_W,
  localparam int unsigned PAIRS = VEC_W / DST_W
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic             sext_i,
  input  logic             sub_i,
  output logic [VEC_W-1:0] row_o
);
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    hadd_pair #(.SRC_W(SRC_W)) i_pair (
      .even_i (src_i[(2*i)*SRC_W +: SRC_W]),
      .odd_i  (src_i[(2*i+1)*SRC_W +: SRC_W]),
      .sext_i (sext_i),
      .sub_i  (sub_i),
      .res_o  (row_o[i*DST_W +: DST_W])
    );
  end
endmodule

// File: rtl/hadd_widen.sv
module hadd_widen
  import hadd_pkg::*;
#(
  parameter int unsigned VEC_W   = 128,
  parameter int unsigned BASE_W  = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       op_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] data_o
);
  size_e            size;
  op_e              op;
  logic             sext, sub, legal;
  logic [VEC_W-1:0] row_res [NUM_SIZES];
  logic [VEC_W-1:0] res_d;

  always_comb begin
    size  = size_e'(size_i);
    op    = op_e'(op_i);
    sext  = (op == OP_SADD) || (op == OP_SSUB);
    sub   = (op == OP_SSUB);
    legal = (op != OP_RSVD) && (size != SZ_RSVD);
  end

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    hadd_row #(.VEC_W(VEC_W), .SRC_W(BASE_W << g)) i_row (
      .src_i  (src_i),
      .sext_i (sext),
      .sub_i  (sub),
      .row_o  (row_res[g])
    );
  end

  always_comb begin
    res_d = '0;
    if (legal) begin
      unique case (size)
        SZ_BYTE: res_d = row_res[0];
        SZ_HALF: res_d = row_res[1];
        SZ_WORD: res_d = row_res[2];
        default: res_d = '0;
      endcase
    end
  end

  if (REG_OUT) begin : g_reg
    logic             valid_q;
    logic [VEC_W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        data_q  <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) data_q <= res_d;
      end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

    p_valid_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(data_o));
    p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && (size_i == 2'd3 || op_i == 2'd3)) |=> (data_o == '0));
  end else begin : g_comb
    assign valid_o = valid_i;
    assign data_o  = res_d;
  end
endmodule

// File: tb/test_hadd_widen.sv
module test_hadd_widen;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src_i = '0;
  logic [1:0]   size_i = '0;
  logic [1:0]   op_i = '0;
  logic         valid_o;
  logic [127:0] data_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hadd_widen i_hadd_widen (
    .clk_i, .rst_ni, .valid_i, .src_i, .size_i, .op_i, .valid_o, .data_o
  );

  function automatic logic [127:0] model(logic [127:0] src, int sz, int op);
    logic [127:0] out;
    logic [65:0]  m1, m2, a, b, r;
    int ew, n;
    out = '0;
    if (sz > 2 || op > 2) return out;
    ew = 8 << sz;
    n  = 128 / (2 * ew);
    m1 = (66'h1 << ew) - 66'h1;
    m2 = (66'h1 << (2 * ew)) - 66'h1;
    for (int i = 0; i < n; i++) begin
      a = 66'(src >> (2 * i * ew)) & m1;
      b = 66'(src >> ((2 * i + 1) * ew)) & m1;
      if (op != 1) begin
        if (a[ew-1]) a = a | ~m1;
        if (b[ew-1]) b = b | ~m1;
      end
      r = (op == 2) ? (a - b) : (a + b);
      out = out | (128'(r & m2) << (2 * i * ew));
    end
    return out;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check one cycle later; valid stays high for back-to-back
  task automatic run(string req, logic [127:0] src, int sz, int op);
    src_i = src; size_i = 2'(sz); op_i = 2'(op); valid_i = 1'b1;
    @(negedge clk_i);
    check({req, " valid"}, 128'(valid_o), 128'(1));
    check(req, data_o, model(src, sz, op));
  endtask

  task automatic idle();
    valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  function automatic logic [127:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] held;
    logic [127:0] v;
    repeat (3) @(negedge clk_i);
    check("R10 reset valid", 128'(valid_o), 128'(0));
    check("R10 reset data", data_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 after release valid", 128'(valid_o), 128'(0));
    check("R10 after release data", data_o, '0);

    // fixed corner values named in the requirements
    run("R4 ff+ff", {120'h0, 8'hFF, 8'hFF} << 0, 0, 1);
    check("R4 01fe", 128'(data_o[15:0]), 128'(16'h01FE));
    run("R5 80+80", {112'h0, 8'h80, 8'h80}, 0, 0);
    check("R5 ff00", 128'(data_o[15:0]), 128'(16'hFF00));
    run("R6 7f-80", {112'h0, 8'h80, 8'h7F}, 0, 2);
    check("R6 00ff", 128'(data_o[15:0]), 128'(16'h00FF));
    run("R6 80-7f", {112'h0, 8'h7F, 8'h80}, 0, 2);
    check("R6 ff01", 128'(data_o[15:0]), 128'(16'hFF01));
    idle();

    // R1: all byte pairs under each operation
    for (int op = 0; op < 3; op++) begin
      for (int k = 0; k < 8192; k++) begin
        v = '0;
        for (int j = 0; j < 8; j++) v[16*j +: 16] = 16'(k * 8 + j);
        run(op == 1 ? "R1 R4 byte sweep" : (op == 0 ? "R1 R5 byte sweep" : "R1 R6 byte sweep"), v, 0, op);
      end
    end
    idle();

    // R2, R3: corners and random
    for (int sz = 1; sz < 3; sz++) begin
      for (int op = 0; op < 3; op++) begin
        run(sz == 1 ? "R2 zeros" : "R3 zeros", '0, sz, op);
        run(sz == 1 ? "R2 ones" : "R3 ones", '1, sz, op);
        run(sz == 1 ? "R2 minpos" : "R3 minpos", {64{2'b01}}, sz, op);
        run(sz == 1 ? "R2 min-max" : "R3 min-max",
            sz == 1 ? {4{16'h7FFF, 16'h8000}} : {2{32'h7FFFFFFF, 32'h80000000}}, sz, op);
        run(sz == 1 ? "R2 max-min" : "R3 max-min",
            sz == 1 ? {4{16'h8000, 16'h7FFF}} : {2{32'h80000000, 32'h7FFFFFFF}}, sz, op);
        for (int n = 0; n < 400; n++) run(sz == 1 ? "R2 random" : "R3 random", rnd(), sz, op);
      end
    end

    // R9: reserved codes
    for (int n = 0; n < 20; n++) begin
      run("R9 size rsvd", rnd(), 3, n % 3);
      check("R9 size rsvd zero", data_o, '0);
      run("R9 op rsvd", rnd(), n % 3, 3);
      check("R9 op rsvd zero", data_o, '0);
    end

    // R7, R8: idle cycles keep the last result
    run("R8 load", rnd(), 0, 0);
    held = data_o;
    valid_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      src_i = rnd(); op_i = 2'(n % 3); size_i = 2'(n % 3);
      @(negedge clk_i);
      check("R7 idle valid", 128'(valid_o), 128'(0));
      check("R8 hold", data_o, held);
    end
    run("R7 single strobe", rnd(), 2, 2);
    idle();
    check("R7 drop after strobe", 128'(valid_o), 128'(0));

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule